// File: doc/BRIEF.md
# Bank-to-Bank Block Move Engine

This sequencer copies a run of bytes from one 64K bank to another over a single-port byte memory. A caller supplies a source bank byte, a destination bank byte, a 16-bit source pointer, a 16-bit destination pointer and a 16-bit count, chooses ascending or descending order, and pulses start. The engine then moves one byte per fixed 7-cycle slot. Each slot holds one read, one write and one pointer update.

The count holds the number of bytes minus one, so a count of zero moves one byte. Pointers and count wrap inside 16 bits, and the bank bytes never change during a move. Descending order suits a copy whose destination sits above an overlapping source. Ascending order suits the opposite case. Choosing the order is the caller's job.

When the last slot ends, the engine drops busy and pulses done for one cycle. It sets its data bank output to the destination bank and keeps the final pointer and count values.

Top module: `blkmv_engine`

## Requirements
- R1: During and after reset the engine is idle: busy, done, read strobe and write strobe are 0, and the data bank output is 0.
- R2: When idle, a high start_i is sampled at a clock edge and all operands are captured at that edge. From the next cycle busy is 1, and that cycle is slot cycle 0 of the first byte.
- R3: Every byte takes exactly 7 cycles. Cycle 0 asserts the read strobe at address {source bank, source pointer}. Memory returns the byte in cycle 1. Cycle 2 asserts the write strobe at address {destination bank, destination pointer} with that byte. Cycles 1 and 3 to 6 carry no strobe. The bank forms address bits 23:16.
- R4: The pointers and count change only at the end of slot cycle 3, so new values are visible from cycle 4. With dir_down_i=0 both pointers step by +1. With dir_down_i=1 both step by -1. The count always steps by -1.
- R5: Pointer and count arithmetic wraps modulo 2^16 (0xFFFF+1=0x0000, 0x0000-1=0xFFFF), and the bank bytes are never altered.
- R6: A count value N moves exactly N+1 bytes. The move ends after the slot in which the count steps from 0x0000 to 0xFFFF.
- R7: In the cycle after the last slot, busy is 0 and done is 1 for exactly one cycle. The pointer and count outputs then hold their final values until the next start.
- R8: From the done cycle onward, the data bank output equals the destination bank of the finished move.
- R9: A start request while busy has no effect on the running move's addresses, data, direction, length or timing.
- R10: A descending copy whose destination is above an overlapping source, and an ascending copy whose destination is below it, leave the destination holding the original source bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| dir_down_i | input | 1 | 1: pointers step down, 0: pointers step up |
| src_bank_i | input | 8 | Source bank byte |
| dst_bank_i | input | 8 | Destination bank byte |
| src_ptr_i | input | 16 | Initial source pointer |
| dst_ptr_i | input | 16 | Initial destination pointer |
| count_i | input | 16 | Byte count minus one |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 24 | Memory byte address {bank, pointer} |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |
| src_ptr_o | output | 16 | Current source pointer |
| dst_ptr_o | output | 16 | Current destination pointer |
| count_o | output | 16 | Current remaining count |
| data_bank_o | output | 8 | Data bank, set to destination bank on completion |

## Verification
The bench compares every cycle against a behavioural model and goes after a count of zero, pointers that wrap through 0xFFFF/0x0000 in both directions, and copies between two different banks. A design that miscounts the final slot would move one byte too many or too few. A design that carries into the bank would write outside the bank. Overlapping copies in each safe direction are checked against the original source bytes, which exposes a wrong step sign or a write issued before its read. A start pulse injected mid-move checks that a design which reloads operands while busy is caught by diverging addresses.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
    localparam int SLOT_LEN = 7;
    localparam int PH_W     = $clog2(SLOT_LEN);

    typedef logic [PH_W-1:0] phase_t;

    localparam phase_t PH_READ  = phase_t'(0);
    localparam phase_t PH_CAP   = phase_t'(1);
    localparam phase_t PH_WRITE = phase_t'(2);
    localparam phase_t PH_STEP  = phase_t'(3);
    localparam phase_t PH_LAST  = phase_t'(SLOT_LEN - 1);
endpackage

// File: rtl/blkmv_slot_timer.sv
module blkmv_slot_timer
    import blkmv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    output phase_t phase_o,
    output logic   last_o
);
    phase_t phase_d, phase_q;

    always_comb begin
        phase_d = phase_t'(0);
        if (run_i && phase_q != PH_LAST) begin
            phase_d = phase_q + phase_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= phase_t'(0);
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;
    assign last_o  = (phase_q == PH_LAST);
endmodule

// File: rtl/blkmv_ptr_step.sv
module blkmv_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         down_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (down_i) val_o = val_i - ONE;
        else        val_o = val_i + ONE;
    end
endmodule

// File: rtl/blkmv_engine.sv
module blkmv_engine
    import blkmv_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    dir_down_i,
    input  logic [BANK_W-1:0]       src_bank_i,
    input  logic [BANK_W-1:0]       dst_bank_i,
    input  logic [PTR_W-1:0]        src_ptr_i,
    input  logic [PTR_W-1:0]        dst_ptr_i,
    input  logic [PTR_W-1:0]        count_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    mem_re_o,
    output logic                    mem_we_o,
    output logic [PTR_W+BANK_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0]       mem_wdata_o,
    input  logic [DATA_W-1:0]       mem_rdata_i,
    output logic [PTR_W-1:0]        src_ptr_o,
    output logic [PTR_W-1:0]        dst_ptr_o,
    output logic [PTR_W-1:0]        count_o,
    output logic [BANK_W-1:0]       data_bank_o
);
    localparam int N_STEP = 3;   // source pointer, destination pointer, count

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              down;
        logic [BANK_W-1:0] sbank;
        logic [BANK_W-1:0] dbank;
        logic [BANK_W-1:0] dbank_out;
        logic [PTR_W-1:0]  sptr;
        logic [PTR_W-1:0]  dptr;
        logic [PTR_W-1:0]  cnt;
        logic [DATA_W-1:0] hold;
    } eng_t;

    eng_t   st_d, st_q;
    phase_t phase;
    logic   slot_last;

    logic [PTR_W-1:0] stp_in  [N_STEP];
    logic [PTR_W-1:0] stp_out [N_STEP];

    assign stp_in[0] = st_q.sptr;
    assign stp_in[1] = st_q.dptr;
    assign stp_in[2] = st_q.cnt;

    blkmv_slot_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (st_q.busy),
        .phase_o (phase),
        .last_o  (slot_last)
    );

    // Pointers follow the chosen direction; the count always steps down.
    for (genvar g = 0; g < N_STEP; g++) begin : g_step
        blkmv_ptr_step #(.W(PTR_W)) u_step (
            .val_i  (stp_in[g]),
            .down_i ((g == N_STEP - 1) ? 1'b1 : st_q.down),
            .val_o  (stp_out[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.down  = dir_down_i;
                st_d.sbank = src_bank_i;
                st_d.dbank = dst_bank_i;
                st_d.sptr  = src_ptr_i;
                st_d.dptr  = dst_ptr_i;
                st_d.cnt   = count_i;
            end
        end else begin
            case (phase)
                PH_CAP:  st_d.hold = mem_rdata_i;
                PH_STEP: begin
                    st_d.sptr = stp_out[0];
                    st_d.dptr = stp_out[1];
                    st_d.cnt  = stp_out[2];
                end
                default: ;
            endcase
            if (slot_last && st_q.cnt == '1) begin
                st_d.busy      = 1'b0;
                st_d.done      = 1'b1;
                st_d.dbank_out = st_q.dbank;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;
    assign mem_re_o    = st_q.busy && (phase == PH_READ);
    assign mem_we_o    = st_q.busy && (phase == PH_WRITE);
    assign mem_addr_o  = mem_re_o ? {st_q.sbank, st_q.sptr} : {st_q.dbank, st_q.dptr};
    assign mem_wdata_o = st_q.hold;
    assign src_ptr_o   = st_q.sptr;
    assign dst_ptr_o   = st_q.dptr;
    assign count_o     = st_q.cnt;
    assign data_bank_o = st_q.dbank_out;

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re_o && mem_we_o)); // R3
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_re_o, 2)); // R3
    AST_PTR_STILL_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && phase != PH_STEP) |=> ($stable(st_q.sptr) && $stable(st_q.dptr))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start_i) |=> ($stable(src_ptr_o) && $stable(count_o))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DATA_BANK_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (data_bank_o == st_q.dbank)); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i) |=> ($stable(st_q.sbank) && $stable(st_q.dbank) && $stable(st_q.down))); // R9
endmodule

// File: tb/blkmv_engine_tb_top.sv
module blkmv_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_down_i = 1'b0;
    logic [7:0]  src_bank_i = '0, dst_bank_i = '0;
    logic [15:0] src_ptr_i = '0, dst_ptr_i = '0, count_i = '0;
    logic        busy_o, done_o, mem_re_o, mem_we_o;
    logic [23:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic [15:0] src_ptr_o, dst_ptr_o, count_o;
    logic [7:0]  data_bank_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_dbank = '0;

    logic [7:0] mem    [int];
    logic [7:0] shadow [int];

    always #5 clk = ~clk;

    blkmv_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_down_i(dir_down_i),
        .src_bank_i(src_bank_i), .dst_bank_i(dst_bank_i), .src_ptr_i(src_ptr_i),
        .dst_ptr_i(dst_ptr_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
        .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .src_ptr_o(src_ptr_o),
        .dst_ptr_o(dst_ptr_o), .count_o(count_o), .data_bank_o(data_bank_o)
    );

    function automatic logic [7:0] seed(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mem_rd(logic [23:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : seed(a);
    endfunction

    function automatic logic [7:0] shadow_rd(logic [23:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : seed(a);
    endfunction

    // Byte memory: read data appears the cycle after the read strobe.
    always @(posedge clk) begin
        if (mem_re_o) mem_rdata_i <= mem_rd(mem_addr_o);
        if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] step(logic [15:0] v, bit dn);
        return dn ? v - 16'd1 : v + 16'd1;
    endfunction

    task automatic run_move(input logic [7:0] sb, input logic [7:0] db, input logic [15:0] x,
                            input logic [15:0] y, input int c, input bit dn, input bit poke);
        logic [15:0] xs, ys, cs;
        logic [7:0]  val;
        logic [7:0]  orig [$];
        logic [15:0] p;
        p = x;
        for (int i = 0; i <= c; i++) begin
            orig.push_back(mem_rd({sb, p}));
            p = step(p, dn);
        end
        @(negedge clk);
        start_i = 1'b1; dir_down_i = dn; src_bank_i = sb; dst_bank_i = db;
        src_ptr_i = x; dst_ptr_i = y; count_i = 16'(c);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
        xs = x; ys = y; cs = 16'(c);
        for (int n = 0; n <= c; n++) begin
            val = shadow_rd({sb, xs});
            for (int ph = 0; ph < 7; ph++) begin
                chk(busy_o === 1'b1 && done_o === 1'b0, "R6 busy within move",
                    {30'd0, busy_o, done_o}, 32'd2);
                chk(mem_re_o === (ph == 0), "R3 read strobe slot", 32'(mem_re_o), 32'(ph == 0));
                chk(mem_we_o === (ph == 2), "R3 write strobe slot", 32'(mem_we_o), 32'(ph == 2));
                if (ph == 0) chk(mem_addr_o === {sb, xs}, "R3 read address", 32'(mem_addr_o), 32'({sb, xs}));
                if (ph == 2) begin
                    chk(mem_addr_o === {db, ys}, "R3 write address", 32'(mem_addr_o), 32'({db, ys}));
                    chk(mem_wdata_o === val, "R3 write data", 32'(mem_wdata_o), 32'(val));
                end
                chk(src_ptr_o === (ph >= 4 ? step(xs, dn) : xs), "R4 R5 source pointer",
                    32'(src_ptr_o), 32'(ph >= 4 ? step(xs, dn) : xs));
                chk(dst_ptr_o === (ph >= 4 ? step(ys, dn) : ys), "R4 R5 destination pointer",
                    32'(dst_ptr_o), 32'(ph >= 4 ? step(ys, dn) : ys));
                chk(count_o === (ph >= 4 ? cs - 16'd1 : cs), "R4 count",
                    32'(count_o), 32'(ph >= 4 ? cs - 16'd1 : cs));
                chk(data_bank_o === exp_dbank, "R8 data bank during move", 32'(data_bank_o), 32'(exp_dbank));
                if (poke && n == 0 && ph == 3) begin
                    start_i = 1'b1; dir_down_i = ~dn; src_bank_i = 8'hEE; dst_bank_i = 8'hDD;
                    src_ptr_i = 16'h1234; dst_ptr_i = 16'h4321; count_i = 16'h0040;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            shadow[int'({db, ys})] = val;
            xs = step(xs, dn); ys = step(ys, dn); cs = cs - 16'd1;
        end
        exp_dbank = db;
        chk(busy_o === 1'b0 && done_o === 1'b1, "R7 R6 done after last slot",
            {30'd0, busy_o, done_o}, 32'd1);
        chk(data_bank_o === db, "R8 data bank at done", 32'(data_bank_o), 32'(db));
        chk(count_o === 16'hFFFF, "R6 final count", 32'(count_o), 32'hFFFF);
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R7 done one cycle", {30'd0, busy_o, done_o}, 32'd0);
        chk(src_ptr_o === xs && dst_ptr_o === ys, "R7 final pointers held",
            {src_ptr_o, dst_ptr_o}, {xs, ys});
        chk(mem_re_o === 1'b0 && mem_we_o === 1'b0, "R7 no strobes when idle",
            {30'd0, mem_re_o, mem_we_o}, 32'd0);
        p = y;
        for (int i = 0; i <= c; i++) begin
            chk(mem_rd({db, p}) === orig[i], "R10 destination content", 32'(mem_rd({db, p})), 32'(orig[i]));
            p = step(p, dn);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1 busy/done in reset", {30'd0, busy_o, done_o}, 32'd0);
        chk(mem_re_o === 1'b0 && mem_we_o === 1'b0, "R1 strobes in reset", {30'd0, mem_re_o, mem_we_o}, 32'd0);
        chk(data_bank_o === 8'h00, "R1 data bank in reset", 32'(data_bank_o), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_o === 1'b0 && mem_re_o === 1'b0, "R1 idle after reset", {30'd0, busy_o, mem_re_o}, 32'd0);

        run_move(8'h03, 8'h07, 16'h1000, 16'h2000, 0, 1'b0, 1'b0);   // R6 single byte
        run_move(8'h01, 8'h02, 16'h0040, 16'h0080, 4, 1'b0, 1'b0);   // R4 ascending
        run_move(8'h05, 8'h05, 16'h0300, 16'h0400, 3, 1'b1, 1'b0);   // R4 descending
        run_move(8'h10, 8'h11, 16'hFFFE, 16'hFFFD, 3, 1'b0, 1'b0);   // R5 upward wrap
        run_move(8'h20, 8'h21, 16'h0001, 16'h0002, 3, 1'b1, 1'b0);   // R5 downward wrap
        run_move(8'h09, 8'h09, 16'h0117, 16'h011A, 7, 1'b1, 1'b0);   // R10 overlap, dst above
        run_move(8'h09, 8'h09, 16'h0220, 16'h021C, 5, 1'b0, 1'b0);   // R10 overlap, dst below
        run_move(8'h0A, 8'h0B, 16'h0500, 16'h0600, 2, 1'b0, 1'b1);   // R9 start while busy

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule